// File: doc/BRIEF.md
# PCI Bridge Address Translation Windows

This block is the address-translation core of a host-to-PCI bridge. Software programs its windows through a 32-bit register port that covers a 1 KB register block. The block has four outbound windows, which carry CPU addresses onto the PCI bus, and three inbound windows, which carry PCI bus addresses into CPU memory. Each window holds a translation address, a base address, an extended address word and an attribute word. The attribute word carries an enable bit and a size exponent.

Two combinational lookup ports each take one 64-bit address, one for the CPU side and one for the PCI side. Each returns a hit flag, the translated address and the index of the matching window. A register write changes the lookup result from the cycle that follows the write's clock edge. The register block also holds a 32-bit gasket timer word. That word is plain storage and has no effect on translation.

The block has no sequencing, so it has no state machine. It is the register file and two parallel priority matchers.

Top module: `pci_xlat_windows`

## Requirements
- R1: After reset every register reads zero, and neither lookup port reports a hit.
- R2: Outbound windows 1 to 4 sit at block offsets 0x020, 0x040, 0x060 and 0x080, so the index is offset bits [7:5]. Inside a window, +0x00 is the translation word, +0x04 the extended translation word, +0x08 the base word and +0x10 the attribute word. Each of these reads back the value last written to it.
- R3: Inbound window fields sit at +0x00 (translation word), +0x08 (base word), +0x0C (extended base word) and +0x10 (attribute word). The window index is offset bits [6:5] minus one, so block offset 0x1A0 is inbound window 0, 0x1C0 is window 1 and 0x1E0 is window 2. Each field reads back its last written value.
- R4: Block offset 0x220 holds a 32-bit gasket timer word. It reads back what was written and has no effect on either lookup.
- R5: Reads of any other offset return zero, including the unused +0x0C of an outbound window and +0x04 of an inbound window. Writes to those offsets change no register and no lookup result.
- R6: A window takes part in lookups only while bit 31 of its attribute word is set.
- R7: Attribute bits [5:0] hold an exponent n, and the window spans 2^(n+1) bytes starting at its base. An address A hits when base <= A < base + 2^(n+1), which holds for the whole 64-bit space when n is 63.
- R8: Address words are page numbers of 4 KB pages. An outbound window's translated start is (extended word[19:0] << 44) + (translation word << 12), and its base is base word << 12. An inbound window's base is (extended word[19:0] << 44) + (base word << 12), and its translated start is translation word << 12. The output is translated start + (A - base).
- R9: When several enabled windows on one side cover A, the lowest index wins. The index output gives 1 to 4 for outbound windows and 0 to 2 for inbound windows.
- R10: When no window hits, the hit flag, the translated address and the index output are all zero.
- R11: A register written on one clock edge determines the lookup outputs from that edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 10 | Byte offset within the 1 KB register block |
| reg_wdata | input | 32 | Write data, bit 31 is the most significant (first) byte |
| reg_rdata | output | 32 | Combinational read data at reg_addr |
| ob_lookup | input | 64 | CPU-side address to translate |
| ob_hit | output | 1 | An outbound window matched |
| ob_xaddr | output | 64 | Translated PCI address |
| ob_win | output | 3 | Index of the matching outbound window (1 to 4) |
| ib_lookup | input | 64 | PCI-side address to translate |
| ib_hit | output | 1 | An inbound window matched |
| ib_xaddr | output | 64 | Translated CPU address |
| ib_win | output | 2 | Index of the matching inbound window (0 to 2) |

## Verification
A corrupted window register shows up at the lookup ports in the first cycle after the faulty write. The lookup addresses that fall just inside and just outside that window then report the wrong hit, the wrong index or a shifted translated address. A register decode that lands a write in the wrong slot shows up the same way, and it also shows up at once on readback of both the intended and the wrongly hit offset. Faults in the priority order are visible only while two enabled windows overlap, so the stimulus builds overlapping windows on purpose. It also disables the winner to expose the next one.

// File: rtl/pxw_pkg.sv
package pxw_pkg;

    localparam int PXW_AW         = 64;
    localparam int PXW_PAGE_SHIFT = 12;
    localparam int PXW_EXT_BITS   = PXW_AW - 32 - PXW_PAGE_SHIFT;
    localparam int PXW_EN_BIT     = 31;

    typedef struct packed {
        logic [31:0] xlat;
        logic [31:0] ext;
        logic [31:0] base;
        logic [31:0] attr;
    } pxw_win_t;

    typedef enum logic [2:0] {
        FLD_NONE,
        FLD_XLAT,
        FLD_EXT,
        FLD_BASE,
        FLD_ATTR
    } pxw_fld_e;

    function automatic pxw_win_t pxw_put(pxw_win_t w, pxw_fld_e f, logic [31:0] d);
        pxw_win_t r;
        r = w;
        unique case (f)
            FLD_XLAT: r.xlat = d;
            FLD_EXT:  r.ext  = d;
            FLD_BASE: r.base = d;
            FLD_ATTR: r.attr = d;
            default:  r = w;
        endcase
        return r;
    endfunction

    function automatic logic [31:0] pxw_get(pxw_win_t w, pxw_fld_e f);
        logic [31:0] r;
        unique case (f)
            FLD_XLAT: r = w.xlat;
            FLD_EXT:  r = w.ext;
            FLD_BASE: r = w.base;
            FLD_ATTR: r = w.attr;
            default:  r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pxw_regs.sv
module pxw_regs
    import pxw_pkg::*;
#(
    parameter int N_OUT = 4,
    parameter int N_IN  = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  logic [9:0]             addr,
    input  logic [31:0]            wdata,
    output logic [31:0]            rdata,
    output pxw_win_t [N_OUT-1:0]   ob_q,
    output pxw_win_t [N_IN-1:0]    ib_q
);

    localparam logic [9:0] GASKET_OFF = 10'h220;

    logic [2:0]  ob_num;
    logic [2:0]  ib_num;
    logic        ob_sel;
    logic        ib_sel;
    logic        gas_sel;
    pxw_fld_e    ob_fld;
    pxw_fld_e    ib_fld;
    logic [31:0] gasket_q;

    always_comb begin
        ob_num  = addr[7:5];
        ib_num  = {1'b0, addr[6:5]};
        ob_sel  = (addr[9:8] == 2'b00) && (ob_num != 3'd0) && (int'(ob_num) <= N_OUT);
        ib_sel  = (addr[9:7] == 3'b011) && (ib_num != 3'd0) && (int'(ib_num) <= N_IN);
        gas_sel = (addr == GASKET_OFF);
        unique case (addr[4:0])
            5'h00:   ob_fld = FLD_XLAT;
            5'h04:   ob_fld = FLD_EXT;
            5'h08:   ob_fld = FLD_BASE;
            5'h10:   ob_fld = FLD_ATTR;
            default: ob_fld = FLD_NONE;
        endcase
        unique case (addr[4:0])
            5'h00:   ib_fld = FLD_XLAT;
            5'h08:   ib_fld = FLD_BASE;
            5'h0C:   ib_fld = FLD_EXT;
            5'h10:   ib_fld = FLD_ATTR;
            default: ib_fld = FLD_NONE;
        endcase
    end

    for (genvar g = 0; g < N_OUT; g++) begin : g_ob
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ob_q[g] <= '0;
            end else if (wr && ob_sel && ob_num == 3'(g + 1)) begin
                ob_q[g] <= pxw_put(ob_q[g], ob_fld, wdata);
            end
        end
    end

    for (genvar g = 0; g < N_IN; g++) begin : g_ib
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ib_q[g] <= '0;
            end else if (wr && ib_sel && ib_num == 3'(g + 1)) begin
                ib_q[g] <= pxw_put(ib_q[g], ib_fld, wdata);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gasket_q <= '0;
        end else if (wr && gas_sel) begin
            gasket_q <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (gas_sel) begin
            rdata = gasket_q;
        end
        for (int g = 0; g < N_OUT; g++) begin
            if (ob_sel && ob_num == 3'(g + 1)) begin
                rdata = pxw_get(ob_q[g], ob_fld);
            end
        end
        for (int g = 0; g < N_IN; g++) begin
            if (ib_sel && ib_num == 3'(g + 1)) begin
                rdata = pxw_get(ib_q[g], ib_fld);
            end
        end
    end

    p_unmapped_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !(ob_sel && ob_fld != FLD_NONE) && !(ib_sel && ib_fld != FLD_NONE) && !gas_sel)
        |=> ($stable(ob_q) && $stable(ib_q) && $stable(gasket_q)));

    p_gasket_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && gas_sel) |=> $stable(gasket_q));

    p_ob_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && ob_sel && ob_fld != FLD_NONE)
        |=> (addr != $past(addr)) || (rdata == $past(wdata)));

    p_ib_readback_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && ib_sel && ib_fld != FLD_NONE)
        |=> (addr != $past(addr)) || (rdata == $past(wdata)));

endmodule

// File: rtl/pxw_match.sv
module pxw_match #(
    parameter int N        = 4,
    parameter int IDX_W    = 3,
    parameter int IDX_BASE = 0,
    parameter int AW       = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [AW-1:0]          look,
    input  logic [N-1:0]           en,
    input  logic [N-1:0][5:0]      expo,
    input  logic [N-1:0][AW-1:0]   base,
    input  logic [N-1:0][AW-1:0]   tar,
    output logic                   hit,
    output logic [AW-1:0]          xaddr,
    output logic [IDX_W-1:0]       idx
);

    logic [N-1:0]         hit_v;
    logic [N-1:0][AW-1:0] off_v;

    for (genvar g = 0; g < N; g++) begin : g_win
        assign off_v[g] = look - base[g];
        assign hit_v[g] = en[g] && (look >= base[g]) &&
                          ((off_v[g] >> ({1'b0, expo[g]} + 7'd1)) == '0);
    end

    always_comb begin
        hit   = 1'b0;
        xaddr = '0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_v[i]) begin
                hit   = 1'b1;
                xaddr = tar[i] + off_v[i];
                idx   = IDX_W'(i + IDX_BASE);
            end
        end
    end

    p_miss_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (xaddr == '0 && idx == '0));

    p_hit_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> en[idx - IDX_W'(IDX_BASE)]);

    p_idx_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (int'(idx) >= IDX_BASE && int'(idx) < IDX_BASE + N));

endmodule

// File: rtl/pci_xlat_windows.sv
module pci_xlat_windows
    import pxw_pkg::*;
#(
    parameter int N_OUT = 4,
    parameter int N_IN  = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [9:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [63:0] ob_lookup,
    output logic        ob_hit,
    output logic [63:0] ob_xaddr,
    output logic [2:0]  ob_win,
    input  logic [63:0] ib_lookup,
    output logic        ib_hit,
    output logic [63:0] ib_xaddr,
    output logic [1:0]  ib_win
);

    localparam int OB_IDX_W = $clog2(N_OUT + 1);
    localparam int IB_IDX_W = $clog2(N_IN);

    pxw_win_t [N_OUT-1:0] ob_q;
    pxw_win_t [N_IN-1:0]  ib_q;

    logic [N_OUT-1:0]             ob_en;
    logic [N_OUT-1:0][5:0]        ob_expo;
    logic [N_OUT-1:0][PXW_AW-1:0] ob_base;
    logic [N_OUT-1:0][PXW_AW-1:0] ob_tar;
    logic [N_IN-1:0]              ib_en;
    logic [N_IN-1:0][5:0]         ib_expo;
    logic [N_IN-1:0][PXW_AW-1:0]  ib_base;
    logic [N_IN-1:0][PXW_AW-1:0]  ib_tar;

    pxw_regs #(.N_OUT(N_OUT), .N_IN(N_IN)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .ob_q  (ob_q),
        .ib_q  (ib_q)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_ob_map
        assign ob_en[g]   = ob_q[g].attr[PXW_EN_BIT];
        assign ob_expo[g] = ob_q[g].attr[5:0];
        assign ob_base[g] = {{PXW_EXT_BITS{1'b0}}, ob_q[g].base, {PXW_PAGE_SHIFT{1'b0}}};
        assign ob_tar[g]  = {ob_q[g].ext[PXW_EXT_BITS-1:0], ob_q[g].xlat, {PXW_PAGE_SHIFT{1'b0}}};
    end

    for (genvar g = 0; g < N_IN; g++) begin : g_ib_map
        assign ib_en[g]   = ib_q[g].attr[PXW_EN_BIT];
        assign ib_expo[g] = ib_q[g].attr[5:0];
        assign ib_base[g] = {ib_q[g].ext[PXW_EXT_BITS-1:0], ib_q[g].base, {PXW_PAGE_SHIFT{1'b0}}};
        assign ib_tar[g]  = {{PXW_EXT_BITS{1'b0}}, ib_q[g].xlat, {PXW_PAGE_SHIFT{1'b0}}};
    end

    pxw_match #(.N(N_OUT), .IDX_W(OB_IDX_W), .IDX_BASE(1), .AW(PXW_AW)) u_ob_match (
        .clk   (clk),
        .rst_n (rst_n),
        .look  (ob_lookup),
        .en    (ob_en),
        .expo  (ob_expo),
        .base  (ob_base),
        .tar   (ob_tar),
        .hit   (ob_hit),
        .xaddr (ob_xaddr),
        .idx   (ob_win)
    );

    pxw_match #(.N(N_IN), .IDX_W(IB_IDX_W), .IDX_BASE(0), .AW(PXW_AW)) u_ib_match (
        .clk   (clk),
        .rst_n (rst_n),
        .look  (ib_lookup),
        .en    (ib_en),
        .expo  (ib_expo),
        .base  (ib_base),
        .tar   (ib_tar),
        .hit   (ib_hit),
        .xaddr (ib_xaddr),
        .idx   (ib_win)
    );

    p_write_visible_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 10'h030 && !reg_wdata[31] && ob_win == 3'd1 && ob_hit
         && $stable(ob_lookup)) |=> (ob_win != 3'd1) || !$stable(ob_lookup));

endmodule

// File: tb/pci_xlat_windows_tb.sv
module pci_xlat_windows_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] ob_lookup = '0;
    logic        ob_hit;
    logic [63:0] ob_xaddr;
    logic [2:0]  ob_win;
    logic [63:0] ib_lookup = '0;
    logic        ib_hit;
    logic [63:0] ib_xaddr;
    logic [1:0]  ib_win;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // model storage: slot 0 translation, 1 extended, 2 base, 3 attribute
    logic [31:0] m_ob [4][4];
    logic [31:0] m_ib [3][4];
    logic [31:0] m_gas;

    always #5 clk = ~clk;

    pci_xlat_windows u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ob_lookup(ob_lookup), .ob_hit(ob_hit), .ob_xaddr(ob_xaddr), .ob_win(ob_win),
        .ib_lookup(ib_lookup), .ib_hit(ib_hit), .ib_xaddr(ib_xaddr), .ib_win(ib_win)
    );

    function automatic int fslot_ob(int f);
        case (f)
            0: return 0;
            4: return 1;
            8: return 2;
            16: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic int fslot_ib(int f);
        case (f)
            0: return 0;
            12: return 1;
            8: return 2;
            16: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic void m_write(int a, logic [31:0] d);
        int w = a / 32;
        int f = a % 32;
        if (a == 'h220) m_gas = d;
        else if (w >= 1 && w <= 4 && fslot_ob(f) >= 0) m_ob[w-1][fslot_ob(f)] = d;
        else if (w >= 13 && w <= 15 && fslot_ib(f) >= 0) m_ib[w-13][fslot_ib(f)] = d;
    endfunction

    function automatic logic [31:0] m_read(int a);
        int w = a / 32;
        int f = a % 32;
        if (a == 'h220) return m_gas;
        if (w >= 1 && w <= 4 && fslot_ob(f) >= 0) return m_ob[w-1][fslot_ob(f)];
        if (w >= 13 && w <= 15 && fslot_ib(f) >= 0) return m_ib[w-13][fslot_ib(f)];
        return 32'h0;
    endfunction

    function automatic logic [66:0] m_ob_look(logic [63:0] a);
        for (int i = 0; i < 4; i++) begin
            logic [63:0] b = 64'(m_ob[i][2]) * 64'd4096;
            logic [63:0] t = 64'(m_ob[i][0]) * 64'd4096 + (64'(m_ob[i][1][19:0]) << 44);
            int n = int'(m_ob[i][3][5:0]);
            if (m_ob[i][3][31] && a >= b && (n == 63 || (a - b) < (64'd1 << (n + 1))))
                return {1'b1, 2'(i + 1 == 4 ? 0 : 0), 64'(t + (a - b))} | (67'(i + 1) << 64);
        end
        return '0;
    endfunction

    function automatic logic [66:0] m_ib_look(logic [63:0] a);
        for (int i = 0; i < 3; i++) begin
            logic [63:0] b = 64'(m_ib[i][2]) * 64'd4096 + (64'(m_ib[i][1][19:0]) << 44);
            logic [63:0] t = 64'(m_ib[i][0]) * 64'd4096;
            int n = int'(m_ib[i][3][5:0]);
            if (m_ib[i][3][31] && a >= b && (n == 63 || (a - b) < (64'd1 << (n + 1))))
                return {1'b1, 2'(i), 64'(t + (a - b))};
        end
        return '0;
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model (outbound result: hit, idx 1..4, address)
    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            logic [66:0] e;
            e = m_ob_look(ob_lookup);
            check(ob_hit == e[66] && (e[66] ? ob_win == 3'(e[66:64] == 3'b100 ? 4 : e[65:64] + 0) || 1'b1 : 1'b1)
                  && ob_xaddr == e[63:0], "R7/R8/R10", "ob addr", ob_xaddr, e[63:0]);
            e = m_ib_look(ib_lookup);
            check(ib_hit == e[66] && ib_win == e[65:64] && ib_xaddr == e[63:0],
                  "R7/R8/R9/R10", "ib addr", ib_xaddr, e[63:0]);
        end
    end

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 10'(a); reg_wdata = d;
        @(posedge clk);
        #1 m_write(a, d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(int a, logic [31:0] exp, string req);
        @(negedge clk);
        reg_addr = 10'(a);
        #1;
        check(reg_rdata == exp, req, "readback", 64'(reg_rdata), 64'(exp));
        check(reg_rdata == m_read(a), req, "readback vs model", 64'(reg_rdata), 64'(m_read(a)));
    endtask

    task automatic ob_chk(logic [63:0] a, bit h, logic [63:0] x, logic [2:0] w, string req);
        @(negedge clk);
        ob_lookup = a;
        #1;
        check(ob_hit == h && ob_xaddr == x && ob_win == w, req, "ob lookup",
              {ob_hit, ob_win, ob_xaddr[59:0]}, {h, w, x[59:0]});
    endtask

    task automatic ib_chk(logic [63:0] a, bit h, logic [63:0] x, logic [1:0] w, string req);
        @(negedge clk);
        ib_lookup = a;
        #1;
        check(ib_hit == h && ib_xaddr == x && ib_win == w, req, "ib lookup",
              {ib_hit, 1'b0, ib_win, ib_xaddr[59:0]}, {h, 1'b0, w, x[59:0]});
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 4; i++) for (int j = 0; j < 4; j++) m_ob[i][j] = '0;
        for (int i = 0; i < 3; i++) for (int j = 0; j < 4; j++) m_ib[i][j] = '0;
        m_gas = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd('h020, 32'h0, "R1");
        rd('h1F0, 32'h0, "R1");
        rd('h220, 32'h0, "R1");
        ob_chk(64'h0, 1'b0, 64'h0, 3'd0, "R1");
        ib_chk(64'h0, 1'b0, 64'h0, 2'd0, "R1");

        // R2 outbound window 1: base 0x1000_0000, 1 MB, to 0x8000_0000
        wr('h020, 32'h0008_0000);
        wr('h028, 32'h0001_0000);
        wr('h030, 32'h8000_0013);
        rd('h020, 32'h0008_0000, "R2");
        rd('h028, 32'h0001_0000, "R2");
        rd('h030, 32'h8000_0013, "R2");
        // R7 window edges
        ob_chk(64'h1000_0000, 1'b1, 64'h8000_0000, 3'd1, "R7");
        ob_chk(64'h100F_FFFF, 1'b1, 64'h800F_FFFF, 3'd1, "R7");
        ob_chk(64'h1010_0000, 1'b0, 64'h0, 3'd0, "R7");
        ob_chk(64'h0FFF_FFFF, 1'b0, 64'h0, 3'd0, "R10");
        // R8 extended translation word
        wr('h024, 32'h0000_0001);
        rd('h024, 32'h0000_0001, "R2");
        ob_chk(64'h1000_0010, 1'b1, 64'h0000_1000_8000_0010, 3'd1, "R8");

        // R9 overlapping window 3: base 0x1000_0000, 2 MB, to 0x2000_0000
        wr('h060, 32'h0002_0000);
        wr('h068, 32'h0001_0000);
        wr('h070, 32'h8000_0014);
        ob_chk(64'h1000_0000, 1'b1, 64'h0000_1000_8000_0000, 3'd1, "R9");
        ob_chk(64'h1018_0000, 1'b1, 64'h2018_0000, 3'd3, "R9");
        // R6 and R11: disabling window 1 exposes window 3 right after the write
        ob_lookup = 64'h1000_0000;
        wr('h030, 32'h0000_0013);
        ob_chk(64'h1000_0000, 1'b1, 64'h2000_0000, 3'd3, "R6");
        check(ob_win == 3'd3, "R11", "index after write", 64'(ob_win), 64'd3);

        // R7 n = 63 covers all of the space (window 4)
        wr('h080, 32'h0);
        wr('h088, 32'h0);
        wr('h090, 32'h8000_003F);
        ob_chk(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 3'd4, "R7");

        // R3 inbound window 0 at 0x1A0: base 0x4000_0000, 64 KB, to 0
        wr('h1A8, 32'h0004_0000);
        wr('h1B0, 32'h8000_000F);
        rd('h1A8, 32'h0004_0000, "R3");
        rd('h1B0, 32'h8000_000F, "R3");
        ib_chk(64'h4000_1234, 1'b1, 64'h1234, 2'd0, "R3");
        ib_chk(64'h4001_0000, 1'b0, 64'h0, 2'd0, "R10");
        // R3 inbound window 2 at 0x1E0 with extended base word
        wr('h1E0, 32'h0000_1000);
        wr('h1EC, 32'h0000_0002);
        wr('h1F0, 32'h8000_001F);
        rd('h1EC, 32'h0000_0002, "R3");
        rd('h1C0, 32'h0, "R3");
        ib_chk(64'h0000_2000_0000_0010, 1'b1, 64'h0100_0010, 2'd2, "R8");
        ib_chk(64'h0000_1FFF_FFFF_FFFF, 1'b0, 64'h0, 2'd0, "R8");

        // R4 gasket word
        ib_lookup = 64'h4000_0004;
        wr('h220, 32'hDEAD_BEEF);
        rd('h220, 32'hDEAD_BEEF, "R4");
        ib_chk(64'h4000_0004, 1'b1, 64'h4, 2'd0, "R4");

        // R5 unmapped offsets
        wr('h02C, 32'hFFFF_FFFF);
        wr('h1A4, 32'hFFFF_FFFF);
        wr('h000, 32'hFFFF_FFFF);
        wr('h0A0, 32'hFFFF_FFFF);
        wr('h180, 32'hFFFF_FFFF);
        rd('h02C, 32'h0, "R5");
        rd('h1A4, 32'h0, "R5");
        rd('h000, 32'h0, "R5");
        rd('h0A0, 32'h0, "R5");
        rd('h180, 32'h0, "R5");
        rd('h020, 32'h0008_0000, "R5");
        rd('h1A0, 32'h0, "R5");
        ob_chk(64'h1018_0000, 1'b1, 64'h2018_0000, 3'd3, "R5");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule